// File: doc/BRIEF.md
# Extended Control Register and Byte FIFO

This block is the register window that sits beside an ECP-capable parallel port. It holds the extended control register, a configuration byte and a small byte FIFO. The host reaches it through a simple byte-wide access strobe with a 3-bit offset. The upper three bits of the extended control register select the port's operating mode. The lowest two bits report whether the FIFO is empty, full or partly filled.

In the FIFO test mode the host fills and drains the FIFO directly through offset 0. This lets software find the FIFO's depth and check its ordering without any cable traffic. In every other mode offset 0 is an ordinary data byte. Writing a different mode into the extended control register discards whatever the FIFO holds. Read data is registered, so it is valid on the cycle after the access.

Top module: `ecr_fifo_port`

## Requirements
- R1: After reset the extended control register reads 0x01 (compatible mode, FIFO empty). The configuration byte and the offset-0 data byte both read 0x00.
- R2: Bits 7:5 of the extended control register hold the mode. The encodings are 000 compatible, 001 byte, 010 PP-FIFO, 011 ECP-FIFO, 100 EPP, 101 reserved, 110 FIFO test and 111 configuration. A write to offset 2 replaces all three mode bits. Bits 4:2 read back as last written.
- R3: Bits 1:0 of the extended control register give the FIFO state: 01 empty, 10 full, 00 partly filled. Values written to these two bits are ignored.
- R4: Outside FIFO test mode, offset 0 is a plain read/write byte and the FIFO is untouched.
- R5: In FIFO test mode (110), a write to offset 0 pushes a byte and a read from offset 0 pops one. Bytes come out in the order they went in. The FIFO holds 2 bytes by default.
- R6: A push into a full FIFO is dropped. A pop from an empty FIFO returns 0xFF and changes nothing.
- R7: The read and write positions wrap to zero after the last entry, so ordering holds over any number of fill and drain rounds.
- R8: Writing offset 2 with a mode different from the current one empties the FIFO. Writing the same mode keeps its contents.
- R9: Offset 1 is a read/write configuration byte.
- R10: Offsets 3 to 7 ignore writes and read as 0xFF.
- R11: An access with the byte qualifier low changes no state and reads 0xFF. In FIFO test mode such an access does not pop.
- R12: Read data appears on `rd_data` one clock after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_byte | input | 1 | Access is byte sized; other sizes are ignored |
| acc_off | input | 3 | Register offset in the window |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume that each access is a single-cycle strobe with stable offset, direction and data. They also assume the byte qualifier is known whenever the strobe is high. The directed bench drives every access on the falling edge for exactly one cycle and then returns the strobe low. It samples on the next falling edge, so every check sits inside those assumptions. The bench reaches full, empty and wrap-around only through legal host accesses.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        MODE_COMPAT    = 3'd0,
        MODE_BYTE      = 3'd1,
        MODE_PP_FIFO   = 3'd2,
        MODE_ECP_FIFO  = 3'd3,
        MODE_EPP       = 3'd4,
        MODE_RSVD      = 3'd5,
        MODE_FIFO_TEST = 3'd6,
        MODE_CONFIG    = 3'd7
    } chip_mode_e;

    localparam logic [1:0] FST_PARTIAL = 2'b00;
    localparam logic [1:0] FST_EMPTY   = 2'b01;
    localparam logic [1:0] FST_FULL    = 2'b10;

    localparam int unsigned OFF_FIFO = 0;
    localparam int unsigned OFF_CFGB = 1;
    localparam int unsigned OFF_ECR  = 2;

    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    function automatic logic [1:0] fifo_status(input logic empty, input logic full);
        if (empty)
            return FST_EMPTY;
        else if (full)
            return FST_FULL;
        else
            return FST_PARTIAL;
    endfunction

endpackage

// File: rtl/ecr_byte_fifo.sv
module ecr_byte_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        if (p == LAST_PTR)
            return '0;
        else
            return p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != FULL_CNT);
        do_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr_ptr] = wdata;
                st_d.wr_ptr           = step_ptr(st_q.wr_ptr);
            end
            if (do_pop) begin
                st_d.rd_ptr = step_ptr(st_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd_ptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);
    assign level = st_q.cnt;

    // R5: occupancy never exceeds the depth
    a_r5_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT);

    // R6: pushing into a full FIFO leaves it full with the same level
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(level)));

    // R8: a flush leaves the FIFO empty
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R7: a lone pop lowers the level by exactly one
    a_r7_pop_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && !empty) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/ecr_reg_file.sv
module ecr_reg_file
    import ecr_pkg::*;
#(
    parameter int unsigned OFF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_byte,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [BYTE_W-1:0] acc_wdata,
    input  logic [BYTE_W-1:0] fifo_head,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output logic [BYTE_W-1:0] rd_data
);

    localparam logic [OFF_W-1:0] SEL_FIFO = OFF_W'(OFF_FIFO);
    localparam logic [OFF_W-1:0] SEL_CFGB = OFF_W'(OFF_CFGB);
    localparam logic [OFF_W-1:0] SEL_ECR  = OFF_W'(OFF_ECR);

    typedef struct packed {
        chip_mode_e        mode;
        logic [2:0]        misc;
        logic [BYTE_W-1:0] cfgb;
        logic [BYTE_W-1:0] pdata;
        logic [BYTE_W-1:0] rdata;
    } reg_st_t;

    reg_st_t    st_d, st_q;
    logic       wr_ok, rd_ok, in_test;
    chip_mode_e wr_mode;
    logic [BYTE_W-1:0] ecr_view;
    logic [1:0] unused_status_bits;

    assign unused_status_bits = acc_wdata[1:0];

    always_comb begin
        st_d       = st_q;
        wr_ok      = acc_en && acc_byte && acc_wr;
        rd_ok      = acc_en && acc_byte && !acc_wr;
        in_test    = (st_q.mode == MODE_FIFO_TEST);
        wr_mode    = chip_mode_e'(acc_wdata[7:5]);
        ecr_view   = {st_q.mode, st_q.misc, fifo_status(fifo_empty, fifo_full)};
        fifo_push  = 1'b0;
        fifo_pop   = 1'b0;
        fifo_flush = 1'b0;

        if (wr_ok) begin
            case (acc_off)
                SEL_FIFO: begin
                    if (in_test)
                        fifo_push = !fifo_full;
                    else
                        st_d.pdata = acc_wdata;
                end
                SEL_CFGB: st_d.cfgb = acc_wdata;
                SEL_ECR: begin
                    st_d.mode  = wr_mode;
                    st_d.misc  = acc_wdata[4:2];
                    fifo_flush = (wr_mode != st_q.mode);
                end
                default: ;
            endcase
        end

        if (acc_en && !acc_wr) begin
            st_d.rdata = IDLE_BYTE;
            if (rd_ok) begin
                case (acc_off)
                    SEL_FIFO: begin
                        if (in_test) begin
                            if (!fifo_empty) begin
                                fifo_pop   = 1'b1;
                                st_d.rdata = fifo_head;
                            end
                        end else begin
                            st_d.rdata = st_q.pdata;
                        end
                    end
                    SEL_CFGB: st_d.rdata = st_q.cfgb;
                    SEL_ECR:  st_d.rdata = ecr_view;
                    default:  st_d.rdata = IDLE_BYTE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_COMPAT;
            st_q.misc  <= '0;
            st_q.cfgb  <= '0;
            st_q.pdata <= '0;
            st_q.rdata <= IDLE_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;

    // R2: a byte write to offset 2 installs all three mode bits
    a_r2_mode_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_byte && acc_off == SEL_ECR)
        |=> (st_q.mode == $past(acc_wdata[7:5])));

    // R10: unimplemented offsets read as all ones
    a_r10_unimpl_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_byte && acc_off > SEL_ECR) |=> (rd_data == IDLE_BYTE));

    // R11: a non-byte read returns all ones
    a_r11_nonbyte_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !acc_byte) |=> (rd_data == IDLE_BYTE));

    // R11: a non-byte write leaves the registers as they were
    a_r11_nonbyte_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !acc_byte)
        |=> ($stable(st_q.mode) && $stable(st_q.cfgb) && $stable(st_q.pdata)));

    // R6: popping an empty FIFO in test mode yields all ones
    a_r6_empty_pop_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && acc_off == SEL_FIFO && in_test && fifo_empty) |=> (rd_data == IDLE_BYTE));

    // R12: read data only moves after a read access
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> $stable(rd_data));

endmodule

// File: rtl/ecr_fifo_port.sv
module ecr_fifo_port
    import ecr_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 2,
    parameter int unsigned OFF_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_byte,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        rd_data
);

    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              push, pop, flush;
    logic              empty, full;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  level;

    ecr_reg_file #(
        .OFF_W (OFF_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .acc_byte   (acc_byte),
        .acc_off    (acc_off),
        .acc_wdata  (acc_wdata),
        .fifo_head  (head),
        .fifo_empty (empty),
        .fifo_full  (full),
        .fifo_push  (push),
        .fifo_pop   (pop),
        .fifo_flush (flush),
        .rd_data    (rd_data)
    );

    ecr_byte_fifo #(
        .DATA_W (BYTE_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .wdata (acc_wdata),
        .head  (head),
        .empty (empty),
        .full  (full),
        .level (level)
    );

    // R3: empty and full never report together
    a_r3_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R5: the FIFO is never asked to push and pop in one cycle
    a_r5_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: tb/test_ecr_fifo_port.sv
module test_ecr_fifo_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic       acc_byte = 1'b1;
    logic [2:0] acc_off = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ecr_fifo_port i_ecr_fifo_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_byte  (acc_byte),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata),
        .rd_data   (rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-port FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [7:0] val, input bit is_byte = 1'b1);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_off = off; acc_wdata = val; acc_byte = is_byte;
        @(negedge clk);
        acc_en = 1'b0; acc_byte = 1'b1;
    endtask

    task automatic rd(input logic [2:0] off, output logic [7:0] v, input bit is_byte = 1'b1);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_off = off; acc_byte = is_byte;
        @(negedge clk);
        acc_en = 1'b0; acc_byte = 1'b1;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd2, v); chk("R1 ecr", v, 8'h01);
        rd(3'd1, v); chk("R1 cfgb", v, 8'h00);
        rd(3'd0, v); chk("R1 data", v, 8'h00);
    endtask

    task automatic t_modes;
        logic [7:0] v;
        wr(3'd2, 8'h3E);
        rd(3'd2, v); chk("R2 R3 mode byte, status write ignored", v, 8'h3D);
        wr(3'd2, 8'hE0);
        rd(3'd2, v); chk("R2 mode replaced", v, 8'hE1);
        wr(3'd2, 8'h20);
        wr(3'd0, 8'h5A);
        rd(3'd0, v); chk("R4 plain data byte", v, 8'h5A);
        rd(3'd2, v); chk("R4 fifo untouched", v, 8'h21);
    endtask

    task automatic t_fifo_basic;
        logic [7:0] v;
        wr(3'd2, 8'hC0);
        rd(3'd2, v); chk("R3 empty", v, 8'hC1);
        wr(3'd0, 8'h11);
        rd(3'd2, v); chk("R3 partial", v, 8'hC0);
        wr(3'd0, 8'h22);
        rd(3'd2, v); chk("R3 full", v, 8'hC2);
        wr(3'd0, 8'h33);
        rd(3'd2, v); chk("R6 push when full dropped", v, 8'hC2);
        rd(3'd0, v); chk("R5 first out", v, 8'h11);
        rd(3'd0, v); chk("R5 second out", v, 8'h22);
        rd(3'd2, v); chk("R5 empty after drain", v, 8'hC1);
        rd(3'd0, v); chk("R6 empty pop", v, 8'hFF);
        rd(3'd2, v); chk("R6 still empty", v, 8'hC1);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        wr(3'd0, 8'h90);
        rd(3'd0, v); chk("R7 phase shift", v, 8'h90);
        for (int i = 0; i < 4; i++) begin
            wr(3'd0, 8'(8'h40 + 2 * i));
            wr(3'd0, 8'(8'h41 + 2 * i));
            rd(3'd0, v); chk("R7 wrap order a", v, 8'(8'h40 + 2 * i));
            rd(3'd0, v); chk("R7 wrap order b", v, 8'(8'h41 + 2 * i));
        end
    endtask

    task automatic t_flush;
        logic [7:0] v;
        wr(3'd0, 8'h77);
        wr(3'd2, 8'hC0);
        rd(3'd2, v); chk("R8 same mode keeps", v, 8'hC0);
        rd(3'd0, v); chk("R8 same mode data", v, 8'h77);
        wr(3'd0, 8'h88);
        wr(3'd0, 8'h99);
        wr(3'd2, 8'h20);
        rd(3'd2, v); chk("R8 mode change empties", v, 8'h21);
        wr(3'd2, 8'hC0);
        rd(3'd0, v); chk("R8 nothing left", v, 8'hFF);
    endtask

    task automatic t_cfg_unimpl;
        logic [7:0] v;
        wr(3'd1, 8'hA5);
        rd(3'd1, v); chk("R9 cfgb", v, 8'hA5);
        for (int o = 3; o < 8; o++) begin
            wr(3'(o), 8'h00);
            rd(3'(o), v); chk("R10 unimplemented reads ff", v, 8'hFF);
        end
        rd(3'd1, v); chk("R10 cfgb kept", v, 8'hA5);
        rd(3'd2, v); chk("R10 ecr kept", v, 8'hC1);
    endtask

    task automatic t_nonbyte;
        logic [7:0] v;
        wr(3'd1, 8'h00, 1'b0);
        rd(3'd1, v); chk("R11 nonbyte write ignored", v, 8'hA5);
        wr(3'd2, 8'h00, 1'b0);
        rd(3'd2, v); chk("R11 nonbyte ecr write ignored", v, 8'hC1);
        wr(3'd0, 8'h3C);
        rd(3'd0, v, 1'b0); chk("R11 nonbyte read ff", v, 8'hFF);
        rd(3'd0, v); chk("R11 no pop on nonbyte", v, 8'h3C);
    endtask

    task automatic t_latency;
        logic [7:0] v;
        rd(3'd1, v); chk("R12 prior read", v, 8'hA5);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_off = 3'd2;
        #2;
        chk("R12 not yet updated", rd_data, 8'hA5);
        @(negedge clk);
        acc_en = 1'b0;
        chk("R12 one cycle later", rd_data, 8'hC1);
        repeat (3) @(negedge clk);
        chk("R12 holds", rd_data, 8'hC1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_modes;
        t_fifo_basic;
        t_wrap;
        t_flush;
        t_cfg_unimpl;
        t_nonbyte;
        t_latency;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("Watchdog FAIL: run did not finish, got timeout expected completion");
        finish_run;
    end

endmodule